// File: doc/BRIEF.md
# Periodic reload timer

A 16-bit down-counting timer on a simple 32-bit register bus. It has three registers in a 256-byte window: a control register, a reload register and a read-only live count. Software programs a reload value, sets the enable bit to start the counter, and reads the count while it runs. The counter steps once per tick. Each tick is produced by a prescaler that divides the system clock by `TICK_DIV`, so the default gives 1 MHz from a 100 MHz clock. When the count is at zero on a tick, it reloads from the reload register.

The bus is a single-cycle strobe. `req_i` qualifies the access and `we_i` selects a write. Only full-word accesses, with every byte enable set, have any effect. Read data is registered and appears in the cycle after the read strobe.

Three behaviours are easy to miss. The control reset bit wipes the block and discards the rest of its write. Clearing the enable bit does not stop a counter that is already running. Writing the reload register replaces the live count at once.

Top module: `reload_timer`

## Requirements
- R1: After the active-low reset `rst_ni`, the counter is stopped and reads of control (0x00), reload (0x08) and count (0x0C) return zero.
- R2: A full-word write to control (0x00) with bit 31 clear stores all 32 written bits, and a later read of 0x00 returns them unchanged.
- R3: A full-word write to control with bit 31 set stops the counter and clears the control, reload and count registers. All other bits of that write are discarded, and the count stays zero afterwards.
- R4: A control write with bit 31 clear and bit 0 set starts the counter and restarts the prescaler. The count first drops by one `TICK_DIV` cycles after that write, and then once every `TICK_DIV` cycles.
- R5: A control write with bit 0 clear does not stop a counter that is already running.
- R6: A write to reload (0x08) keeps bits [15:0], reads back with bits [31:16] zero, loads that value into the count in the same cycle, and restarts the prescaler.
- R7: A tick that finds the count at zero loads the reload value instead of wrapping. With a reload value of zero, the count stays at zero.
- R8: Writes to count (0x0C) have no effect, and a read of 0x0C returns the live count zero-extended from 16 bits.
- R9: Reads of any other offset, including 0x04 and misaligned offsets, return zero, and writes to those offsets change no register.
- R10: An access whose byte enable `be_i` is not all ones is ignored: a write changes nothing and a read returns zero.
- R11: `rdata_o` carries the read value in the cycle after a read strobe and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the window |
| be_i | input | DATA_W/8 | Byte enables, all ones for a valid access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The bench builds the timer with `TICK_DIV` = 4 and the default 16-bit count. A small divider makes each tick only a few cycles apart. That keeps several reload-at-zero events, the zero-reload hold, and ticks that coincide with writes within a short run. The register bus and count widths are kept at their defaults, so the masking of reload bits [31:16] and the full 32-bit readback of control are exercised as built.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h08;
  localparam logic [7:0] OFS_COUNT  = 8'h0C;
  localparam int CTRL_SRST_BIT = 31;
  localparam int CTRL_EN_BIT   = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_COUNT
  } reg_sel_e;
endpackage

// File: rtl/timer_regs.sv
`timescale 1ns/1ps
module timer_regs
  import timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [CNT_W-1:0]    reload_o,
  output logic [CNT_W-1:0]    load_val_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                soft_rst_o,
  output logic                start_o,
  output logic                load_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e           sel;
  logic               full, wr, rd, ctrl_wr;
  logic [DATA_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   reload_q;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      ADDR_W'(OFS_RELOAD): sel = SEL_RELOAD;
      ADDR_W'(OFS_COUNT):  sel = SEL_COUNT;
      default:             sel = SEL_NONE;
    endcase
  end

  assign full = &be_i;
  assign wr   = req_i & we_i & full;
  assign rd   = req_i & ~we_i & full;

  // reset bit overrides every other bit of a control write
  assign soft_rst_o = wr && (sel == SEL_CTRL) && wdata_i[CTRL_SRST_BIT];
  assign ctrl_wr    = wr && (sel == SEL_CTRL) && !wdata_i[CTRL_SRST_BIT];
  assign start_o    = ctrl_wr && wdata_i[CTRL_EN_BIT];
  assign load_o     = wr && (sel == SEL_RELOAD);
  assign load_val_o = wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (soft_rst_o) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q   <= wdata_i;
      if (load_o)  reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
      SEL_COUNT:  rd_mux = {{PAD_W{1'b0}}, cnt_i};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_mux : '0;
  end

  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler #(
  parameter int TICK_DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  // a restart cycle never ticks; phase starts again from zero
  assign tick_o = run_i && (pre_q == LAST) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (pre_q == LAST)      pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
module timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (soft_rst_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (start_i) run_q <= 1'b1;
      if (load_i)
        cnt_q <= load_val_i;
      else if (tick_i)
        cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
module reload_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic             soft_rst, start, load, tick, run_q, restart;
  logic [CNT_W-1:0] reload_q, load_val, cnt_q;

  assign restart = soft_rst | start | load;

  timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .be_i       (be_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .reload_o   (reload_q),
    .load_val_o (load_val),
    .rdata_o    (rdata_o),
    .soft_rst_o (soft_rst),
    .start_o    (start),
    .load_o     (load)
  );

  timer_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (restart),
    .tick_o    (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .start_i    (start),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload_q),
    .tick_i     (tick),
    .run_o      (run_q),
    .cnt_o      (cnt_q)
  );
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W/8-1:0] be_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [DATA_W-1:0]   ctrl_q,
  input logic [CNT_W-1:0]    reload_q,
  input logic [CNT_W-1:0]    cnt_q,
  input logic                run_q,
  input logic                tick
);
  logic full, ctrl_hit, rel_hit, mapped;
  assign full     = &be_i;
  assign ctrl_hit = addr_i == ADDR_W'(8'h00);
  assign rel_hit  = addr_i == ADDR_W'(8'h08);
  assign mapped   = ctrl_hit || rel_hit || (addr_i == ADDR_W'(8'h0C));

  a_r3_soft_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && full && ctrl_hit && wdata_i[31]
    |=> ctrl_q == '0 && reload_q == '0 && cnt_q == '0 && !run_q);

  a_r5_enable_clear_keeps_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && req_i && we_i && full && ctrl_hit && !wdata_i[31] && !wdata_i[0]
    |=> run_q);

  a_r6_reload_loads_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && full && rel_hit
    |=> cnt_q == $past(wdata_i[CNT_W-1:0]) && reload_q == cnt_q);

  a_r7_zero_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q == '0 && !req_i
    |=> cnt_q == $past(reload_q));

  a_r4_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q != '0 && !req_i
    |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  a_r4_stopped_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !tick);

  a_r9_unmapped_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !mapped
    |=> $stable(ctrl_q) && $stable(reload_q));

  a_r10_partial_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !full
    |=> $stable(ctrl_q) && $stable(reload_q) && $stable(run_q));

  a_r11_rdata_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i && full)
    |=> rdata_o == '0);
endmodule

bind reload_timer timer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .be_i     (be_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .ctrl_q   (u_regs.ctrl_q),
  .reload_q (reload_q),
  .cnt_q    (cnt_q),
  .run_q    (run_q),
  .tick     (tick)
);

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  reload_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(16), .TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_ctrl;
  logic [15:0] m_rel, m_cnt;
  bit          m_run;
  int          m_pre;

  function automatic logic [31:0] read_value(logic [7:0] a);
    case (a)
      8'h00:   return m_ctrl;
      8'h08:   return {16'h0, m_rel};
      8'h0C:   return {16'h0, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one bus cycle; called and returns at a falling edge
  task automatic cyc(bit rq, bit w, logic [7:0] a, logic [3:0] b, logic [31:0] d,
                     string tag, bit chk);
    bit full, wr, rd, srst, cwr, start, load, restart, tick;
    logic [31:0] exp;
    full    = (b == 4'hF);
    wr      = rq && w && full;
    rd      = rq && !w && full;
    srst    = wr && a == 8'h00 && d[31];
    cwr     = wr && a == 8'h00 && !d[31];
    start   = cwr && d[0];
    load    = wr && a == 8'h08;
    restart = srst || start || load;
    tick    = m_run && (m_pre == DIV - 1) && !restart;
    exp     = rd ? read_value(a) : 32'h0;
    if (restart || !m_run) m_pre = 0;
    else m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
    if (srst) begin
      m_ctrl = '0; m_rel = '0; m_cnt = '0; m_run = 0;
    end else begin
      if (cwr) m_ctrl = d;
      if (start) m_run = 1;
      if (load) begin
        m_rel = d[15:0]; m_cnt = d[15:0];
      end else if (tick) begin
        m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 16'd1;
      end
    end
    req = rq; we = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    if (chk) check(tag, rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1, 1, a, 4'hF, d, "", 0);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cyc(1, 0, a, 4'hF, 32'h0, tag, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h0, 4'h0, 32'h0, "", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [7:0] regs [4];
    regs[0] = 8'h00; regs[1] = 8'h08; regs[2] = 8'h0C; regs[3] = 8'h04;
    seed = $urandom(32'd4242);
    m_ctrl = '0; m_rel = '0; m_cnt = '0; m_run = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, "R1 ctrl"); rd(8'h08, "R1 reload"); rd(8'h0C, "R1 count");
    // R2 full readback, enable clear so not running
    wr(8'h00, 32'h5A5A_0002); rd(8'h00, "R2 ctrl readback");
    idle(6); rd(8'h0C, "R2 still stopped");
    // R6 reload masks and loads count
    wr(8'h08, 32'hABCD_0003); rd(8'h08, "R6 reload masked"); rd(8'h0C, "R6 count loaded");
    // R4 start, then R7 reload at zero
    wr(8'h00, 32'h0000_0001);
    for (int i = 0; i < 24; i++) rd(8'h0C, "R4 R7 counting");
    // R5 clearing enable keeps running
    wr(8'h00, 32'h0000_0000);
    for (int i = 0; i < 10; i++) rd(8'h0C, "R5 still running");
    // R8 count writes ignored
    cyc(1, 1, 8'h0C, 4'hF, 32'h0000_FFFF, "", 0);
    rd(8'h0C, "R8 count after write"); rd(8'h08, "R8 reload unchanged");
    // R9 unmapped
    wr(8'h04, 32'hFFFF_FFFE); wr(8'h09, 32'h0000_1234);
    rd(8'h04, "R9 read 0x04"); rd(8'h10, "R9 read 0x10"); rd(8'h09, "R9 read 0x09");
    rd(8'h00, "R9 ctrl unchanged"); rd(8'h08, "R9 reload unchanged");
    // R10 partial byte enables
    cyc(1, 1, 8'h08, 4'h3, 32'h0000_0007, "", 0);
    cyc(1, 0, 8'h08, 4'h7, 32'h0, "R10 partial read", 1);
    rd(8'h08, "R10 reload unchanged");
    // R11 idle cycle after a read
    rd(8'h08, "R11 read");
    cyc(0, 0, 8'h08, 4'hF, 32'h0, "R11 idle zero", 1);
    // R3 soft reset discards other bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R3 ctrl cleared"); rd(8'h08, "R3 reload cleared");
    idle(9); rd(8'h0C, "R3 count stopped at zero");
    // R7 zero reload holds zero
    wr(8'h08, 32'h0); wr(8'h00, 32'h1);
    for (int i = 0; i < 12; i++) rd(8'h0C, "R7 zero hold");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 31);
      if (op < 10)       idle(1);
      else if (op < 17)  rd(regs[$urandom_range(0, 3)], "R4 R8 random read");
      else if (op < 20)  wr(8'h08, {$urandom_range(0, 65535), 16'h0} | 32'($urandom_range(0, 9)));
      else if (op < 22)  wr(8'h00, 32'h0000_0001 | ($urandom() & 32'h7FFF_FFFE));
      else if (op < 24)  wr(8'h00, $urandom() & 32'h7FFF_FFFE);
      else if (op == 24) wr(8'h00, 32'h8000_0000 | $urandom());
      else if (op < 27)  wr(regs[2 + $urandom_range(0, 1)], $urandom());
      else if (op < 29)  cyc(1, $urandom_range(0, 1) == 1, regs[$urandom_range(0, 2)],
                             4'($urandom_range(0, 14)), $urandom(), "R10 random partial", 1);
      else               rd(8'h0C, "R7 random count");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule